// File: doc/BRIEF.md
# Circular Block Sample Writer

This block stores a stream of tagged sample words into a shared memory region as consecutive words. Samples arrive in frames of a fixed number of words. The region is split into equal blocks. The host asks for a number of blocks, and the block records exactly that many, then stops. A counter tracks how much of the current block is still free, and it is debited one frame at a time. When a block fills, the block base moves on by one block. If that move would reach the end of the region, the base returns to the region start and a host event fires.

A start pulse captures three things: the block count, the region base address, and the engine's fixed offset from that base. Recording then begins at the base plus the offset. Each sample accepted on `smp_valid` produces one registered word write on the memory port. `done` rises together with the final write and stays high until the next start.

Top module: `circ_block_writer`

## Requirements
- R1: While reset is asserted and after reset is released, `mem_we`, `done` and `wrap_evt` are low.
- R2: After a start with a non-zero block count, the first accepted sample is written at `region_base + ENGINE_OFFSET`, one cycle after it is accepted.
- R3: Each sample accepted while recording gives exactly one write in the next cycle, carrying the sample word unchanged. Within a block, the address rises by DATA_W/8 bytes per word.
- R4: `smp_valid` is ignored, and no write is issued, before the first start, after `done`, and in the cycle that carries a start pulse.
- R5: The free space in a block is debited by FRAME_WORDS*DATA_W/8 bytes once per completed frame. When it runs out, it reloads to BLOCK_BYTES and the next word goes to the following block base, offset 0.
- R6: When a completed block leaves more blocks to record and the next base would equal REGION_BYTES, the base returns to 0. `wrap_evt` pulses high for exactly one cycle, in the same cycle as the block's last write.
- R7: After the requested number of blocks has been written, recording stops. `done` rises in the cycle of the last write, and the final block raises no `wrap_evt`, even when it ends at the region end.
- R8: A start with a block count of 0 records nothing. `done` is high in the cycle after the start.
- R9: `done` holds until the next start. A start at any time, even mid-recording, restarts recording from the newly captured start address with the new count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins (or restarts) a recording |
| blk_count | input | CNT_W | Number of blocks to record, sampled on start |
| region_base | input | ADDR_W | Byte address of the shared region, sampled on start |
| smp_valid | input | 1 | A sample word is present this cycle |
| smp_data | input | DATA_W | Tagged sample word |
| mem_we | output | 1 | Word write strobe |
| mem_addr | output | ADDR_W | Byte address of the word write |
| mem_wdata | output | DATA_W | Word being written |
| done | output | 1 | Requested blocks recorded, or a zero count was rejected |
| wrap_evt | output | 1 | One-cycle host event when the block base wraps |

## Verification
The bench builds the block with 32-bit words and frames of 8 words. It uses a 64-byte block, so one block is two frames and 16 words. The region is 192 bytes, which holds three blocks and is not a power of two, so the compare form of the wrap detector is the one built. These sizes let a run cross several block boundaries and several base wraps within a few hundred cycles. They also let it end a recording exactly on the region end, where the event must stay quiet. The block counts are random from 1 to 7, and sample gaps come from a random duty, so frame and block ends land on both dense and sparse input.

// File: rtl/cbw_pkg.sv
package cbw_pkg;

   typedef enum logic [1:0] {
      CBW_IDLE = 2'd0,
      CBW_REC  = 2'd1,
      CBW_DONE = 2'd2
   } cbw_state_e;

   function automatic bit is_pow2(longint v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cbw_cursor.sv
// Position inside the region: free bytes left in the block (debited per
// frame), word slot inside the frame, and the current block base.
module cbw_cursor
   import cbw_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int WORD_BYTES   = 4,
   parameter int FRAME_WORDS  = 8,
   parameter int BLOCK_BYTES  = 131072,
   parameter int REGION_BYTES = 1048576
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              accept,
   input  logic              adv_base,
   output logic              blk_end,
   output logic              wrap_now,
   output logic [ADDR_W-1:0] wr_off
);
   localparam int FRAME_BYTES = FRAME_WORDS * WORD_BYTES;
   localparam int REM_W       = $clog2(BLOCK_BYTES + 1);
   localparam int WIF_W       = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
   localparam int BASE_W      = $clog2(REGION_BYTES + 1);

   logic [REM_W-1:0]  rem_q;
   logic [WIF_W-1:0]  wif_q;
   logic [BASE_W-1:0] base_q;
   logic [BASE_W-1:0] base_nx;
   logic              frame_last;
   logic              reached;

   assign frame_last = (wif_q == WIF_W'(FRAME_WORDS - 1));
   assign blk_end    = accept && frame_last && (rem_q == REM_W'(FRAME_BYTES));
   assign base_nx    = base_q + BASE_W'(BLOCK_BYTES);

   generate
      if (is_pow2(REGION_BYTES)) begin : g_wrap_bit
         assign reached = base_nx[BASE_W-1];
      end else begin : g_wrap_cmp
         assign reached = (base_nx == BASE_W'(REGION_BYTES));
      end
   endgenerate

   assign wrap_now = adv_base && reached;
   assign wr_off   = ADDR_W'(base_q) + ADDR_W'(BLOCK_BYTES) - ADDR_W'(rem_q)
                   + ADDR_W'(wif_q) * ADDR_W'(WORD_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         rem_q  <= REM_W'(BLOCK_BYTES);
         wif_q  <= '0;
         base_q <= '0;
      end else if (accept) begin
         if (frame_last) begin
            wif_q <= '0;
            if (rem_q == REM_W'(FRAME_BYTES)) rem_q <= REM_W'(BLOCK_BYTES);
            else                              rem_q <= rem_q - REM_W'(FRAME_BYTES);
         end else begin
            wif_q <= wif_q + WIF_W'(1);
         end
         if (adv_base) base_q <= reached ? '0 : base_nx;
      end
   end

   // R3
   word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !blk_end && !restart |=> wr_off == $past(wr_off) + ADDR_W'(WORD_BYTES));
   // R5
   blk_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_end && !adv_base && !restart |=> rem_q == REM_W'(BLOCK_BYTES) && wif_q == '0);
   // R6
   base_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      base_q < BASE_W'(REGION_BYTES));

endmodule

// File: rtl/cbw_tally.sv
// Blocks still to record and the idle / recording / done sequence.
module cbw_tally
   import cbw_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] count_in,
   input  logic             blk_end,
   output logic             recording,
   output logic             done,
   output logic             final_blk
);
   cbw_state_e       st_q;
   logic [CNT_W-1:0] left_q;

   assign recording = (st_q == CBW_REC);
   assign done      = (st_q == CBW_DONE);
   assign final_blk = (left_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= CBW_IDLE;
         left_q <= '0;
      end else if (start) begin
         left_q <= count_in;
         st_q   <= (count_in == '0) ? CBW_DONE : CBW_REC;
      end else if (blk_end) begin
         left_q <= left_q - CNT_W'(1);
         if (final_blk) st_q <= CBW_DONE;
      end
   end

   // R8
   zero_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && count_in == '0 |=> done && !recording);
   // R9
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);
   // R7
   left_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      recording |-> left_q != '0);

endmodule

// File: rtl/circ_block_writer.sv
module circ_block_writer
   import cbw_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int DATA_W        = 32,
   parameter int CNT_W         = 16,
   parameter int FRAME_WORDS   = 8,
   parameter int BLOCK_BYTES   = 131072,
   parameter int REGION_BYTES  = 1048576,
   parameter int ENGINE_OFFSET = 'h2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  blk_count,
   input  logic [ADDR_W-1:0] region_base,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              done,
   output logic              wrap_evt
);
   localparam int WORD_BYTES  = DATA_W / 8;
   localparam int FRAME_BYTES = FRAME_WORDS * WORD_BYTES;

   initial begin : prm_chk
      assert (DATA_W % 8 == 0 && DATA_W >= 8) else $error("DATA_W must be whole bytes");
      assert (FRAME_WORDS >= 1) else $error("FRAME_WORDS must be positive");
      assert (BLOCK_BYTES % FRAME_BYTES == 0 && BLOCK_BYTES >= FRAME_BYTES)
         else $error("BLOCK_BYTES must hold whole frames");
      assert (REGION_BYTES % BLOCK_BYTES == 0 && REGION_BYTES >= BLOCK_BYTES)
         else $error("REGION_BYTES must hold whole blocks");
   end

   logic              recording;
   logic              final_blk;
   logic              accept;
   logic              adv_base;
   logic              blk_end;
   logic              wrap_now;
   logic [ADDR_W-1:0] wr_off;
   logic [ADDR_W-1:0] start_addr_q;

   assign accept   = recording && smp_valid && !start;
   assign adv_base = blk_end && !final_blk;

   cbw_cursor #(
      .ADDR_W      (ADDR_W),
      .WORD_BYTES  (WORD_BYTES),
      .FRAME_WORDS (FRAME_WORDS),
      .BLOCK_BYTES (BLOCK_BYTES),
      .REGION_BYTES(REGION_BYTES)
   ) u_cursor (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start),
      .accept  (accept),
      .adv_base(adv_base),
      .blk_end (blk_end),
      .wrap_now(wrap_now),
      .wr_off  (wr_off)
   );

   cbw_tally #(
      .CNT_W(CNT_W)
   ) u_tally (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .count_in (blk_count),
      .blk_end  (blk_end),
      .recording(recording),
      .done     (done),
      .final_blk(final_blk)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_addr_q <= '0;
         mem_we       <= 1'b0;
         mem_addr     <= '0;
         mem_wdata    <= '0;
         wrap_evt     <= 1'b0;
      end else begin
         if (start) start_addr_q <= region_base + ADDR_W'(ENGINE_OFFSET);
         mem_we   <= accept;
         wrap_evt <= wrap_now;
         if (accept) begin
            mem_addr  <= start_addr_q + wr_off;
            mem_wdata <= smp_data;
         end
      end
   end

   // R4
   quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !mem_we);
   // R6
   evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt |=> !wrap_evt);
   // R6
   evt_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt |-> mem_we && !done);
   // R2
   first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !mem_we);

endmodule

// File: tb/circ_block_writer_tb.sv
`timescale 1ns/1ps
module circ_block_writer_tb;
   localparam int ADDR_W = 32;
   localparam int DATA_W = 32;
   localparam int CNT_W  = 8;
   localparam int FW     = 8;
   localparam int BLK    = 64;
   localparam int REG    = 192;
   localparam int OFS    = 'h100;
   localparam int NBLK   = REG / BLK;
   localparam int WB     = DATA_W / 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [CNT_W-1:0]  blk_count = '0;
   logic [ADDR_W-1:0] region_base = '0;
   logic              smp_valid = 1'b0;
   logic [DATA_W-1:0] smp_data = '0;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata;
   logic              done;
   logic              wrap_evt;

   always #10 clk = ~clk;

   circ_block_writer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .FRAME_WORDS(FW),
      .BLOCK_BYTES(BLK), .REGION_BYTES(REG), .ENGINE_OFFSET(OFS)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .blk_count(blk_count),
      .region_base(region_base), .smp_valid(smp_valid), .smp_data(smp_data),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .done(done), .wrap_evt(wrap_evt)
   );

   int          n_cmp = 0;
   int          n_bad = 0;
   int          k = 0;
   int          mcnt = 0;
   bit          mrun = 0;
   bit          mdone = 0;
   logic [31:0] mbase = '0;

   function automatic logic [31:0] exp_addr(int idx);
      int byt = idx * WB;
      int bi  = byt / BLK;
      return mbase + 32'(OFS) + 32'((bi % NBLK) * BLK) + 32'(byt % BLK);
   endfunction

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   task automatic step(bit v, logic [31:0] d);
      bit          exp_we;
      bit          exp_wrap = 0;
      bit          was_done = mdone;
      logic [31:0] ea = '0;
      string       atag;
      smp_valid = v;
      smp_data  = d;
      @(posedge clk);
      @(negedge clk);
      smp_valid = 1'b0;
      exp_we = v && mrun;
      if (exp_we) begin
         int bi = (k * WB) / BLK;
         ea = exp_addr(k);
         atag = (k == 0) ? "R2" : (((k * WB) >= BLK) ? "R5" : "R3");
         if (((k + 1) * WB) % BLK == 0) begin
            if (bi + 1 == mcnt) begin mrun = 0; mdone = 1; end
            else if ((bi + 1) % NBLK == 0) exp_wrap = 1;
         end
         k++;
      end
      chk(mem_we == exp_we, (v && !exp_we) ? "R4" : "R3", "write strobe", 32'(mem_we), 32'(exp_we));
      if (exp_we && mem_we) begin
         chk(mem_addr == ea, atag, "write address", mem_addr, ea);
         chk(mem_wdata == d, "R3", "write data", mem_wdata, d);
      end
      chk(wrap_evt == exp_wrap, "R6", "wrap event", 32'(wrap_evt), 32'(exp_wrap));
      chk(done == mdone, was_done ? "R9" : "R7", "done", 32'(done), 32'(mdone));
   endtask

   task automatic do_start(int c, logic [31:0] b, bit v);
      start = 1'b1;
      blk_count = CNT_W'(c);
      region_base = b;
      smp_valid = v;
      smp_data = $urandom;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      smp_valid = 1'b0;
      mrun = (c != 0); mdone = (c == 0); mcnt = c; mbase = b; k = 0;
      chk(mem_we == 1'b0, "R4", "write in start cycle", 32'(mem_we), 32'd0);
      chk(done == mdone, "R8", "done after start", 32'(done), 32'(mdone));
   endtask

   task automatic run_to_end(int density);
      int guard = 0;
      while (mrun && guard < 3000) begin
         step(($urandom % 100) < density, $urandom);
         guard++;
      end
      chk(mdone && done, "R7", "recording finished", 32'(done), 32'd1);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : main
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(mem_we == 0 && done == 0 && wrap_evt == 0, "R1", "outputs in reset",
          {29'd0, mem_we, done, wrap_evt}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_we == 0 && done == 0 && wrap_evt == 0, "R1", "outputs after reset",
          {29'd0, mem_we, done, wrap_evt}, 32'd0);
      // R4: samples before any start are dropped
      step(1, 32'hDEAD_0001);
      step(1, 32'hDEAD_0002);
      // R8: zero count rejected
      do_start(0, 32'h1000, 1);
      for (int i = 0; i < 3; i++) step(1, $urandom);
      // R7: three blocks end exactly at region end, no event
      do_start(3, 32'h2000, 0);
      run_to_end(100);
      // R4 / R9: ignored after done, done holds
      for (int i = 0; i < 4; i++) step(1, $urandom);
      // R6: five blocks, one wrap
      do_start(5, 32'h8000, 0);
      run_to_end(60);
      // R9: restart in the middle of a recording
      do_start(4, 32'h3000, 0);
      for (int i = 0; i < 20; i++) step(1, $urandom);
      do_start(1, 32'hA000, 1);
      run_to_end(70);
      // random recordings
      for (int r = 0; r < 5; r++) begin
         do_start(1 + int'($urandom % 7), $urandom & 32'h00FF_FFFC, 0);
         run_to_end(30 + int'($urandom % 70));
         step(1, $urandom);
      end
      finish_run();
   end

endmodule